// File: doc/BRIEF.md
# Channel Status Block Start Synchronizer

This block keeps the position of the current frame inside a 192-frame channel-status block for a digital audio transmitter. It is advanced by a one-cycle subframe tick. Each frame holds two subframes, so every second tick ends a frame and moves the frame index forward. The index wraps from the last frame back to zero.

When the pass-through (transparent) mode is enabled, an external block-start strobe can force the block boundary to a known point. The block samples the strobe only on selected subframe ticks. With a left/right style frame sync it samples once per frame, on the tick that ends the second subframe. With a word-clock style frame sync it samples on every subframe tick. A sample that is high, taken right after a sample that was low, forces the frame index back to zero on that same clock edge. In that way the transmitter's block follows the block of an upstream receiver. When the mode is disabled, the strobe has no effect and the index runs freely.

Top module: `cs_block_align`

## Requirements
- R1: While `rst` is high and after its release, `frame_idx` is 0 and `blk_start` is 0.
- R2: With no realignment, `frame_idx` increments by one on the clock edge of every second `sub_tick`. It goes from 191 to 0.
- R3: `blk_start` is high for exactly one clock cycle, starting on the edge where `frame_idx` is loaded with 0 (by a wrap or a realignment). It is low at all other times.
- R4: With `sync_fmt` = 0 (left/right sync), the strobe is sampled only on a `sub_tick` that ends the second subframe of a frame. A strobe high on a first-subframe tick is ignored.
- R5: With `sync_fmt` = 1 (word-clock sync), the strobe is sampled on every `sub_tick`. A qualified rise can therefore realign in the middle of a frame.
- R6: A sample of 1, taken when the previous sample was 0, sets `frame_idx` to 0 on that clock edge when `xpar_en` = 1. This overrides any advance on the same edge.
- R7: A strobe that stays high causes no further realignment until a sample of 0 has been taken.
- R8: After reset the previous sample counts as 1. A strobe that is high at the first sample therefore does not realign.
- R9: With `xpar_en` = 0 the strobe never realigns, and the index keeps advancing.
- R10: The first `sub_tick` after reset belongs to the first subframe of frame 0. It does not advance the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xpar_en | input | 1 | Transparent mode enable; gates realignment |
| sync_fmt | input | 1 | 0 = left/right sync (sample per frame), 1 = word clock (sample per subframe) |
| sub_tick | input | 1 | One-cycle pulse at the end of each subframe |
| blk_strobe | input | 1 | External block-start strobe |
| frame_idx | output | 8 | Frame position within the channel-status block, 0 to 191 |
| blk_start | output | 1 | One-cycle pulse when the index becomes 0 |

## Verification
On every cycle, the assertions check these properties:
- The index stays in range.
- The index only steps by one, and only on a frame advance.
- A realignment always leaves the index at zero.
- Realignment happens only on a sample tick, and only in transparent mode.
- In left/right mode every sample falls on a frame end.

Some behaviours appear only in the bench's scenarios: whether sampling falls on the right subframe for each sync format, the low-then-high qualification with the reset value of the history, the suppression of a held strobe, and the exact wrap point from 191 to 0.

// File: rtl/cs_align_pkg.sv
package cs_align_pkg;
  localparam int unsigned FRAMES_PER_BLOCK = 192;
  localparam int unsigned SUBFRAMES_PER_FRAME = 2;

  typedef enum logic {
    SYNC_LR   = 1'b0,
    SYNC_WORD = 1'b1
  } sync_fmt_e;
endpackage

// File: rtl/cs_sub_phase.sv
module cs_sub_phase
  import cs_align_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sub_tick,
  input  sync_fmt_e fmt,
  output logic      frame_adv,
  output logic      sample_en
);
  // phase_q = 1 while waiting for the tick that ends the second subframe
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= 1'b0;
    else if (sub_tick) phase_q <= ~phase_q;
  end

  always_comb begin
    frame_adv = sub_tick & phase_q & ~rst;
    sample_en = sub_tick & ~rst & ((fmt == SYNC_WORD) | phase_q);
  end

  // R4
  lr_sample_at_frame_end_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_en && fmt == SYNC_LR) |-> frame_adv);

  // R10
  adv_every_second_tick_chk: assert property (@(posedge clk) disable iff (rst)
    frame_adv |-> sub_tick);
endmodule

// File: rtl/cs_strobe_qual.sv
module cs_strobe_qual (
  input  logic clk,
  input  logic rst,
  input  logic sample_en,
  input  logic strobe,
  input  logic enable,
  output logic realign
);
  // Previous sample; resets high so a sample of 0 is needed before a rise
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else if (sample_en) prev_q <= strobe;
  end

  always_comb realign = sample_en & enable & ~prev_q & strobe;

  // R7
  no_repeat_realign_chk: assert property (@(posedge clk) disable iff (rst)
    realign |=> !realign);
endmodule

// File: rtl/cs_frame_ctr.sv
module cs_frame_ctr #(
  parameter int unsigned FRAMES = 192,
  localparam int unsigned IDX_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             realign,
  output logic [IDX_W-1:0] idx,
  output logic             start
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

  logic at_last;
  always_comb at_last = (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      start <= 1'b0;
    end else if (realign) begin
      idx   <= '0;
      start <= 1'b1;
    end else if (adv) begin
      idx   <= at_last ? '0 : idx + IDX_W'(1);
      start <= at_last;
    end else begin
      start <= 1'b0;
    end
  end

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST);

  // R6
  realign_zero_chk: assert property (@(posedge clk) disable iff (rst)
    realign |=> (idx == '0 && start));

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !realign && !at_last) |=> (idx == $past(idx) + IDX_W'(1)));

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !realign) |=> ($stable(idx) && !start));
endmodule

// File: rtl/cs_block_align.sv
module cs_block_align
  import cs_align_pkg::*;
#(
  parameter int unsigned FRAMES = FRAMES_PER_BLOCK,
  localparam int unsigned IDX_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xpar_en,
  input  logic             sync_fmt,
  input  logic             sub_tick,
  input  logic             blk_strobe,
  output logic [IDX_W-1:0] frame_idx,
  output logic             blk_start
);
  sync_fmt_e fmt;
  logic      frame_adv;
  logic      sample_en;
  logic      realign;

  always_comb fmt = sync_fmt_e'(sync_fmt);

  cs_sub_phase u_phase (
    .clk       (clk),
    .rst       (rst),
    .sub_tick  (sub_tick),
    .fmt       (fmt),
    .frame_adv (frame_adv),
    .sample_en (sample_en)
  );

  cs_strobe_qual u_qual (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .strobe    (blk_strobe),
    .enable    (xpar_en),
    .realign   (realign)
  );

  cs_frame_ctr #(.FRAMES(FRAMES)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .adv     (frame_adv),
    .realign (realign),
    .idx     (frame_idx),
    .start   (blk_start)
  );

  // R9
  realign_needs_mode_chk: assert property (@(posedge clk) disable iff (rst)
    realign |-> (xpar_en && sample_en));
endmodule

// File: tb/test_cs_block_align.sv
module test_cs_block_align;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xpar_en = 1'b0;
  logic       sync_fmt = 1'b0;
  logic       sub_tick = 1'b0;
  logic       blk_strobe = 1'b0;
  logic [7:0] frame_idx;
  logic       blk_start;

  int n_chk = 0;
  int n_fail = 0;

  always #2ns clk = ~clk;

  cs_block_align i_cs_block_align (
    .clk(clk), .rst(rst), .xpar_en(xpar_en), .sync_fmt(sync_fmt),
    .sub_tick(sub_tick), .blk_strobe(blk_strobe),
    .frame_idx(frame_idx), .blk_start(blk_start)
  );

  // {xpar_en, sync_fmt, strobe, expected idx, expected blk_start}
  localparam int NV = 18;
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b1, 8'd0, 1'b0},  // R4 first-subframe high ignored, R10
    {1'b1, 1'b0, 1'b0, 8'd1, 1'b0},  // R2 advance, sample 0
    {1'b1, 1'b0, 1'b0, 8'd1, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'd2, 1'b0},
    {1'b1, 1'b0, 1'b1, 8'd2, 1'b0},  // R4 not sampled
    {1'b1, 1'b0, 1'b1, 8'd0, 1'b1},  // R6 rise realigns
    {1'b1, 1'b0, 1'b1, 8'd0, 1'b0},
    {1'b1, 1'b0, 1'b1, 8'd1, 1'b0},  // R7 held high, no realign
    {1'b1, 1'b1, 1'b0, 8'd1, 1'b0},  // R5 word mode sample 0
    {1'b1, 1'b1, 1'b1, 8'd0, 1'b1},  // R6 realign beats advance
    {1'b1, 1'b1, 1'b0, 8'd0, 1'b0},
    {1'b1, 1'b1, 1'b1, 8'd0, 1'b1},
    {1'b1, 1'b1, 1'b0, 8'd0, 1'b0},
    {1'b1, 1'b1, 1'b0, 8'd1, 1'b0},
    {1'b1, 1'b1, 1'b1, 8'd0, 1'b1},  // R5 mid-frame realign
    {1'b1, 1'b1, 1'b1, 8'd1, 1'b0},
    {1'b0, 1'b1, 1'b0, 8'd1, 1'b0},
    {1'b0, 1'b1, 1'b1, 8'd2, 1'b0}   // R9 mode off, rise ignored
  };

  task automatic check(input string req, input logic [7:0] idx_exp, input logic blk_exp);
    n_chk++;
    if (frame_idx !== idx_exp || blk_start !== blk_exp) begin
      n_fail++;
      $display("FAIL %s: idx=%0d blk=%0b expected idx=%0d blk=%0b",
               req, frame_idx, blk_start, idx_exp, blk_exp);
    end
  endtask

  // Drive one sub_tick at a negedge; return at the following negedge
  task automatic tick(input logic stb);
    blk_strobe = stb;
    sub_tick = 1'b1;
    @(negedge clk);
    sub_tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    sub_tick = 1'b0;
    blk_strobe = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4ns * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: idx=%0d blk=%0b expected completion", frame_idx, blk_start);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] exp_idx;
    int bad;
    do_reset();
    check("R1 reset", 8'd0, 1'b0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      xpar_en  = VEC[i][11];
      sync_fmt = VEC[i][10];
      tick(VEC[i][9]);
      check($sformatf("R4/R5/R6/R7/R9 vec %0d", i), VEC[i][8:1], VEC[i][0]);
    end

    // R3: the pulse lasts a single cycle
    xpar_en = 1'b1; sync_fmt = 1'b1;
    tick(1'b0);
    tick(1'b1);
    check("R3 pulse on realign", 8'd0, 1'b1);
    @(negedge clk);
    check("R3 pulse drops", 8'd0, 1'b0);

    // R8: a high strobe on the first sample after reset does not realign
    do_reset();
    xpar_en = 1'b1; sync_fmt = 1'b1;
    tick(1'b1);
    check("R8 first sample high", 8'd0, 1'b0);
    tick(1'b1);
    check("R8 held high advances", 8'd1, 1'b0);

    // R2: free run and wrap with mode off
    do_reset();
    xpar_en = 1'b0; sync_fmt = 1'b0;
    exp_idx = 8'd0;
    bad = 0;
    for (int f = 0; f < 191; f++) begin
      tick(1'b1);
      tick(1'b0);
      exp_idx = exp_idx + 8'd1;
      if (frame_idx !== exp_idx) bad++;
    end
    n_chk++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL R2 increment: mismatches=%0d expected 0", bad);
    end
    check("R2 reaches last", 8'd191, 1'b0);
    tick(1'b1);
    check("R2 first subframe holds", 8'd191, 1'b0);
    tick(1'b1);
    check("R2/R3 wrap to zero", 8'd0, 1'b1);
    @(negedge clk);
    check("R3 wrap pulse drops", 8'd0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule